// File: doc/BRIEF.md
# Packed Mixed-Sign Saturating Accumulator

This block adds a source operand into an accumulator operand across a 128-bit destination that is split into packed lanes of 8, 16, 32 or 64 bits. The two operands always differ in signedness. In the unsigned-result mode, a signed source is added to an unsigned accumulator and the sum is clamped to the unsigned range of the lane. In the signed-result mode, an unsigned source is added to a signed accumulator and the sum is clamped to the signed range. The clamp always follows the accumulator's signedness.

An operation is presented with a one-cycle valid strobe. The result is registered and is valid one cycle later. A scalar form works on lane 0 only. A vector form works on all lanes of either the low half or the full width. Every lane that clamps sets a sticky cumulative-saturation flag, which only an explicit clear input resets. The one encoding that is not allowed, 64-bit lanes in a half-width vector, produces an undefined-operation indication in place of a result.

Top module: `mixsat_acc`

## Requirements
- R1: With `mode_i`=0, each lane computes the signed source plus the unsigned accumulator. A negative sum gives zero, a sum above 2^n-1 gives all ones, and any other sum passes through unchanged.
- R2: With `mode_i`=1, each lane computes the unsigned source plus the signed accumulator, clamped to the range -2^(n-1) to 2^(n-1)-1, in two's complement.
- R3: `size_i` selects the lane width: 0 gives 8 bits, 1 gives 16, 2 gives 32 and 3 gives 64. Lane k occupies bits [k*n +: n]. No carry or clamp crosses a lane boundary.
- R4: 64-bit lanes obey the same clamp rules as R1 and R2. This includes unsigned overflow to all ones, underflow to zero, and signed positive overflow to 0x7FFF_FFFF_FFFF_FFFF.
- R5: `qc_o` is set by any saturating active lane of an accepted, legal operation. It stays set until `qc_clr_i` is high at a clock edge. When a clear and a saturating operation arrive at the same edge, the flag ends set.
- R6: The combination `scalar_i`=0, `full_i`=0 and `size_i`=3 is illegal. For that operation, `undef_o` is 1 with the output valid, `result_o` is zero, and `qc_o` is not set.
- R7: With `scalar_i`=1, only lane 0 is computed. All higher result bits are zero, and saturation in higher lanes does not reach `qc_o`. `full_i` is ignored in this form.
- R8: In vector form with `full_i`=0, only lanes inside bits [63:0] are computed. Bits [127:64] read zero, and their saturation does not reach `qc_o`.
- R9: `out_valid_o` is high exactly in the cycle after a cycle with `in_valid_i` high. `result_o` and `undef_o` hold their values until the next accepted operation.
- R10: After reset, `out_valid_o`, `result_o`, `undef_o` and `qc_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operation strobe |
| src_i | input | 128 | Source operand |
| acc_i | input | 128 | Accumulator operand |
| size_i | input | 2 | Lane width code (0:8, 1:16, 2:32, 3:64) |
| mode_i | input | 1 | 0: unsigned result, 1: signed result |
| scalar_i | input | 1 | 1: lane 0 only |
| full_i | input | 1 | Vector width: 1 full 128 bits, 0 low 64 bits |
| qc_clr_i | input | 1 | Clears the sticky saturation flag |
| out_valid_o | output | 1 | Result valid |
| result_o | output | 128 | Saturated result |
| undef_o | output | 1 | Illegal-encoding indication |
| qc_o | output | 1 | Sticky cumulative-saturation flag |

## Verification
Every result, the undefined indication and the flag update fall due at the first rising edge after the edge at which `in_valid_i` or `qc_clr_i` was sampled. A flag clear therefore shows one cycle after it was sampled. The bench's reference model updates its expectations at that same rising edge from the stimulus it drove, using widened integer arithmetic per lane. The bench then compares all four outputs on the following falling edge of every cycle, so no check depends on the order of events at an edge. Directed cases cover the clamp limits of each lane width, flag clear against a simultaneous saturation, and the scalar, half-width and illegal forms. A long random run with operands biased toward extreme values fills in the rest.

// File: rtl/mixsat_pkg.sv
package mixsat_pkg;

  typedef enum logic [1:0] {
    SZ_B = 2'd0,
    SZ_H = 2'd1,
    SZ_W = 2'd2,
    SZ_D = 2'd3
  } lane_size_e;

  typedef enum logic {
    MODE_USAT = 1'b0,
    MODE_SSAT = 1'b1
  } sat_mode_e;

  localparam int unsigned NUM_SIZES = 4;
  localparam int unsigned MIN_LANE_W = 8;

endpackage

// File: rtl/mixsat_lane.sv
module mixsat_lane #(
  parameter int unsigned LANE_W = 8
) (
  input  logic [LANE_W-1:0] src_i,
  input  logic [LANE_W-1:0] acc_i,
  input  logic              mode_i,
  output logic [LANE_W-1:0] res_o,
  output logic              sat_o
);
  import mixsat_pkg::*;

  localparam int unsigned XW = LANE_W + 2;

  // Widened form: both operands extended two bits, range tested on the sum.
  function automatic logic [LANE_W:0] f_wide(input logic [LANE_W-1:0] s,
                                             input logic [LANE_W-1:0] a,
                                             input logic m);
    logic [XW-1:0] sx, ax, sum;
    logic [LANE_W-1:0] r;
    logic sat;
    sat = 1'b0;
    if (m == MODE_USAT) begin
      sx = {{2{s[LANE_W-1]}}, s};
      ax = {2'b00, a};
    end else begin
      sx = {2'b00, s};
      ax = {{2{a[LANE_W-1]}}, a};
    end
    sum = sx + ax;
    r = sum[LANE_W-1:0];
    if (m == MODE_USAT) begin
      if (sum[XW-1]) begin
        r = '0;
        sat = 1'b1;
      end else if (sum[LANE_W]) begin
        r = '1;
        sat = 1'b1;
      end
    end else begin
      if (!sum[XW-1] && (sum[LANE_W] || sum[LANE_W-1])) begin
        r = {1'b0, {(LANE_W-1){1'b1}}};
        sat = 1'b1;
      end else if (sum[XW-1] && !(sum[LANE_W] && sum[LANE_W-1])) begin
        r = {1'b1, {(LANE_W-1){1'b0}}};
        sat = 1'b1;
      end
    end
    return {sat, r};
  endfunction

  // Sign-bit form for the widest lane: no extension beyond the lane.
  function automatic logic [LANE_W:0] f_signbits(input logic [LANE_W-1:0] s,
                                                 input logic [LANE_W-1:0] a,
                                                 input logic m);
    logic [LANE_W-1:0] raw, r, ovf;
    logic sat;
    raw = s + a;
    r = raw;
    sat = 1'b0;
    if (m == MODE_USAT) begin
      if (!s[LANE_W-1] && a[LANE_W-1] && !raw[LANE_W-1]) begin
        r = '1;
        sat = 1'b1;
      end else if (s[LANE_W-1] && !a[LANE_W-1] && raw[LANE_W-1]) begin
        r = '0;
        sat = 1'b1;
      end
    end else begin
      ovf = (s & raw) | (~a & raw) | (s & ~a);
      if (ovf[LANE_W-1]) begin
        r = {1'b0, {(LANE_W-1){1'b1}}};
        sat = 1'b1;
      end
    end
    return {sat, r};
  endfunction

  generate
    if (LANE_W >= 64) begin : g_signbits
      assign {sat_o, res_o} = f_signbits(src_i, acc_i, mode_i);
    end else begin : g_wide
      assign {sat_o, res_o} = f_wide(src_i, acc_i, mode_i);
    end
  endgenerate

  // A clamped lane must sit on one of the limits of its target range.
  always_comb begin
    if (sat_o && mode_i == MODE_USAT) begin
      assert_clamp_unsigned_R1: assert (res_o == '0 || res_o == '1);
    end
    if (sat_o && mode_i == MODE_SSAT) begin
      assert_clamp_signed_R2: assert (res_o == {1'b0, {(LANE_W-1){1'b1}}} ||
                                      res_o == {1'b1, {(LANE_W-1){1'b0}}});
    end
  end

endmodule

// File: rtl/mixsat_mask.sv
module mixsat_mask #(
  parameter int unsigned DATA_W = 128
) (
  input  logic [1:0]          size_i,
  input  logic                scalar_i,
  input  logic                full_i,
  output logic [DATA_W/8-1:0] byte_en_o,
  output logic                illegal_o
);
  import mixsat_pkg::*;

  localparam int unsigned NBYTES = DATA_W / 8;
  localparam int unsigned HALF_BYTES = NBYTES / 2;

  logic [3:0] scalar_bytes;

  assign scalar_bytes = 4'd1 << size_i;
  assign illegal_o = !scalar_i && !full_i && (size_i == SZ_D);

  always_comb begin
    for (int b = 0; b < NBYTES; b++) begin
      if (scalar_i) begin
        byte_en_o[b] = (b < int'({28'd0, scalar_bytes}));
      end else begin
        byte_en_o[b] = full_i || (b < HALF_BYTES);
      end
    end
  end

endmodule

// File: rtl/mixsat_array.sv
module mixsat_array #(
  parameter int unsigned DATA_W = 128
) (
  input  logic [DATA_W-1:0]   src_i,
  input  logic [DATA_W-1:0]   acc_i,
  input  logic [1:0]          size_i,
  input  logic                mode_i,
  input  logic [DATA_W/8-1:0] byte_en_i,
  output logic [DATA_W-1:0]   res_o,
  output logic                sat_any_o
);
  import mixsat_pkg::*;

  localparam int unsigned NBYTES = DATA_W / 8;

  logic [DATA_W-1:0] bit_en;
  logic [NUM_SIZES-1:0][DATA_W-1:0] res_by_sz;
  logic [NUM_SIZES-1:0] sat_by_sz;

  always_comb begin
    for (int b = 0; b < NBYTES; b++) begin
      bit_en[b*8 +: 8] = {8{byte_en_i[b]}};
    end
  end

  genvar gs, gk;
  generate
    for (gs = 0; gs < NUM_SIZES; gs++) begin : g_size
      localparam int unsigned LW = MIN_LANE_W << gs;
      localparam int unsigned NL = DATA_W / LW;
      localparam int unsigned NBL = LW / 8;
      logic [DATA_W-1:0] res_l;
      logic [NL-1:0] sat_l;
      logic [NL-1:0] act_l;
      for (gk = 0; gk < NL; gk++) begin : g_lane
        mixsat_lane #(.LANE_W(LW)) u_lane (
          .src_i (src_i[gk*LW +: LW]),
          .acc_i (acc_i[gk*LW +: LW]),
          .mode_i(mode_i),
          .res_o (res_l[gk*LW +: LW]),
          .sat_o (sat_l[gk])
        );
        assign act_l[gk] = byte_en_i[gk*NBL];
      end
      assign res_by_sz[gs] = res_l & bit_en;
      assign sat_by_sz[gs] = |(sat_l & act_l);
    end
  endgenerate

  assign res_o = res_by_sz[size_i];
  assign sat_any_o = sat_by_sz[size_i];

endmodule

// File: rtl/mixsat_acc.sv
module mixsat_acc #(
  parameter int unsigned DATA_W = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [1:0]        size_i,
  input  logic              mode_i,
  input  logic              scalar_i,
  input  logic              full_i,
  input  logic              qc_clr_i,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] result_o,
  output logic              undef_o,
  output logic              qc_o
);
  import mixsat_pkg::*;

  localparam int unsigned NBYTES = DATA_W / 8;
  localparam int unsigned HALF = DATA_W / 2;

  logic [NBYTES-1:0] byte_en;
  logic              illegal;
  logic [DATA_W-1:0] lane_res;
  logic              sat_any;
  logic              op_sat;
  logic              narrow_q;

  mixsat_mask #(.DATA_W(DATA_W)) u_mask (
    .size_i   (size_i),
    .scalar_i (scalar_i),
    .full_i   (full_i),
    .byte_en_o(byte_en),
    .illegal_o(illegal)
  );

  mixsat_array #(.DATA_W(DATA_W)) u_array (
    .src_i    (src_i),
    .acc_i    (acc_i),
    .size_i   (size_i),
    .mode_i   (mode_i),
    .byte_en_i(byte_en),
    .res_o    (lane_res),
    .sat_any_o(sat_any)
  );

  // Saturation event of an accepted, legal operation.
  assign op_sat = in_valid_i && !illegal && sat_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid_o <= 1'b0;
      result_o    <= '0;
      undef_o     <= 1'b0;
      narrow_q    <= 1'b0;
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) begin
        result_o <= illegal ? '0 : lane_res;
        undef_o  <= illegal;
        narrow_q <= scalar_i || !full_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qc_o <= 1'b0;
    end else begin
      qc_o <= (qc_o && !qc_clr_i) || op_sat;
    end
  end

  assert_valid_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid_i |=> out_valid_o);
  assert_no_stray_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid_i |=> !out_valid_o);
  assert_qc_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    qc_o && !qc_clr_i |=> qc_o);
  assert_qc_only_on_sat_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !op_sat && (!qc_o || qc_clr_i) |=> !qc_o);
  assert_undef_result_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o && undef_o |-> result_o == '0);
  assert_upper_half_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o && narrow_q |-> result_o[DATA_W-1:HALF] == '0);

endmodule

// File: tb/tb_mixsat_acc.sv
module tb_mixsat_acc;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 128;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [DW-1:0] src = '0;
  logic [DW-1:0] acc = '0;
  logic [1:0] size = 2'd0;
  logic mode = 1'b0;
  logic scalar = 1'b0;
  logic full = 1'b1;
  logic qc_clr = 1'b0;
  logic out_valid;
  logic [DW-1:0] result;
  logic undef;
  logic qc;

  int total = 0;
  int bad = 0;
  bit run_chk = 1'b0;
  string cur_tag = "R10";

  logic exp_valid = 1'b0;
  logic [DW-1:0] exp_res = '0;
  logic exp_undef = 1'b0;
  logic exp_qc = 1'b0;
  string exp_tag = "R10";

  always #(CLK_PERIOD/2) clk = ~clk;

  mixsat_acc #(.DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid), .src_i(src), .acc_i(acc),
    .size_i(size), .mode_i(mode), .scalar_i(scalar), .full_i(full),
    .qc_clr_i(qc_clr), .out_valid_o(out_valid), .result_o(result),
    .undef_o(undef), .qc_o(qc)
  );

  // One lane by widened integer arithmetic: returns {sat, result}.
  function automatic logic [64:0] ref_lane(logic [63:0] s, logic [63:0] a, bit m, int n);
    logic signed [67:0] sv, av, sum, lo, hi, one;
    logic [63:0] msk, r;
    bit sat;
    one = 68'sd1;
    msk = (n == 64) ? '1 : ((64'd1 << n) - 64'd1);
    s = s & msk;
    a = a & msk;
    sv = $signed({4'b0, s});
    av = $signed({4'b0, a});
    if (!m && s[n-1]) sv = sv - (one <<< n);
    if (m && a[n-1]) av = av - (one <<< n);
    sum = sv + av;
    if (!m) begin
      lo = 68'sd0;
      hi = (one <<< n) - one;
    end else begin
      lo = -(one <<< (n - 1));
      hi = (one <<< (n - 1)) - one;
    end
    sat = 1'b0;
    if (sum > hi) begin
      sum = hi; sat = 1'b1;
    end else if (sum < lo) begin
      sum = lo; sat = 1'b1;
    end
    r = sum[63:0] & msk;
    return {sat, r};
  endfunction

  // Whole operation: returns {sat_any, result}.
  function automatic logic [DW:0] ref_op(logic [DW-1:0] s, logic [DW-1:0] a,
                                         logic [1:0] sz, bit m, bit sc, bit fu);
    int n;
    int lanes;
    logic [DW-1:0] r;
    bit sat;
    logic [64:0] one_lane;
    n = 8 << sz;
    lanes = sc ? 1 : (fu ? DW / n : (DW / 2) / n);
    r = '0;
    sat = 1'b0;
    for (int k = 0; k < lanes; k++) begin
      one_lane = ref_lane(64'(s >> (k * n)), 64'(a >> (k * n)), m, n);
      sat = sat | one_lane[64];
      r = r | (DW'(one_lane[63:0]) << (k * n));
    end
    return {sat, r};
  endfunction

  // Reference model, updated at the same edge the design registers.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_valid = 1'b0; exp_res = '0; exp_undef = 1'b0; exp_qc = 1'b0;
    end else begin
      logic [DW:0] op;
      bit sat_now;
      sat_now = 1'b0;
      exp_valid = in_valid;
      if (in_valid) begin
        if (!scalar && !full && size == 2'd3) begin
          exp_res = '0;
          exp_undef = 1'b1;
        end else begin
          op = ref_op(src, acc, size, mode, scalar, full);
          exp_res = op[DW-1:0];
          exp_undef = 1'b0;
          sat_now = op[DW];
        end
      end
      exp_qc = (exp_qc && !qc_clr) || sat_now;
      exp_tag = cur_tag;
    end
  end

  always @(negedge clk) begin
    if (rst_n && run_chk) begin
      total++;
      if (out_valid !== exp_valid || result !== exp_res || undef !== exp_undef || qc !== exp_qc) begin
        bad++;
        $display("FAIL %s: got valid=%0b undef=%0b qc=%0b res=%h, expected valid=%0b undef=%0b qc=%0b res=%h",
                 exp_tag, out_valid, undef, qc, result, exp_valid, exp_undef, exp_qc, exp_res);
      end
    end
  end

  task automatic op(input logic [DW-1:0] s, input logic [DW-1:0] a, input logic [1:0] sz,
                    input bit m, input bit sc, input bit fu, input bit cl, input string tag);
    cur_tag = tag;
    src = s; acc = a; size = sz; mode = m; scalar = sc; full = fu; qc_clr = cl;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    qc_clr = 1'b0;
  endtask

  task automatic clear_qc(input string tag);
    cur_tag = tag;
    qc_clr = 1'b1;
    @(negedge clk);
    qc_clr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] pick_byte();
    case ($urandom_range(0, 4))
      0: return 8'h00;
      1: return 8'h7F;
      2: return 8'h80;
      3: return 8'hFF;
      default: return 8'($urandom);
    endcase
  endfunction

  function automatic logic [DW-1:0] pick_word();
    logic [DW-1:0] w;
    for (int b = 0; b < DW / 8; b++) w[b*8 +: 8] = pick_byte();
    return w;
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    total++;
    bad++;
    $display("FAIL watchdog: got no end of run, expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    total++;
    if (out_valid !== 1'b0 || result !== '0 || undef !== 1'b0 || qc !== 1'b0) begin
      bad++;
      $display("FAIL R10: got valid=%0b undef=%0b qc=%0b res=%h, expected all zero",
               out_valid, undef, qc, result);
    end
    rst_n = 1'b1;
    run_chk = 1'b1;
    idle(2);

    // R1: byte lanes, signed source into unsigned accumulator.
    op({16{8'h80}}, {16{8'h10}}, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, "R1");
    op({16{8'h7F}}, {16{8'hF0}}, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, "R1");
    op({16{8'hFF}}, {16{8'h05}}, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, "R1");
    op({8{16'h8000}}, {8{16'h7FFF}}, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0, "R1");
    // R2: unsigned source into signed accumulator.
    op({16{8'hFF}}, {16{8'h80}}, 2'd0, 1'b1, 1'b0, 1'b1, 1'b0, "R2");
    op({16{8'h01}}, {16{8'h7F}}, 2'd0, 1'b1, 1'b0, 1'b1, 1'b0, "R2");
    op({4{32'h0000_0001}}, {4{32'h8000_0000}}, 2'd2, 1'b1, 1'b0, 1'b1, 1'b0, "R2");
    op({4{32'hFFFF_FFFF}}, {4{32'h7FFF_FFFF}}, 2'd2, 1'b1, 1'b0, 1'b1, 1'b0, "R2");
    // R3: alternating lanes, no carry between neighbours.
    op({8{16'h01FF}}, {8{16'h7F01}}, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, "R3");
    op({8{16'h00FF}}, {8{16'h0001}}, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0, "R3");
    // R4: 64-bit lanes.
    op({2{64'h0000_0000_0000_0001}}, {2{64'hFFFF_FFFF_FFFF_FFFF}}, 2'd3, 1'b0, 1'b0, 1'b1, 1'b0, "R4");
    op({2{64'h8000_0000_0000_0000}}, {2{64'h0000_0000_0000_0005}}, 2'd3, 1'b0, 1'b0, 1'b1, 1'b0, "R4");
    op({2{64'hFFFF_FFFF_FFFF_FFFF}}, {2{64'h7FFF_FFFF_FFFF_FFFF}}, 2'd3, 1'b1, 1'b0, 1'b1, 1'b0, "R4");
    op({2{64'h0000_0000_0000_0000}}, {2{64'h8000_0000_0000_0000}}, 2'd3, 1'b1, 1'b0, 1'b1, 1'b0, "R4");
    op({64'h8000_0000_0000_0000, 64'h1}, {64'hFFFF_FFFF_FFFF_FFFF, 64'h2}, 2'd3, 1'b1, 1'b0, 1'b1, 1'b0, "R4");
    // R5: sticky flag, clear, and clear colliding with a saturation.
    idle(2);
    clear_qc("R5");
    idle(2);
    op({16{8'h01}}, {16{8'h01}}, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, "R5");
    op({16{8'h7F}}, {16{8'hFF}}, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, "R5");
    op({16{8'h01}}, {16{8'h01}}, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, "R5");
    idle(3);
    op({16{8'h7F}}, {16{8'hFF}}, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, "R5");
    idle(1);
    clear_qc("R5");
    idle(1);
    // R6: illegal encoding, including lanes that would saturate.
    op({2{64'h1}}, {2{64'hFFFF_FFFF_FFFF_FFFF}}, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, "R6");
    idle(2);
    op({16{8'h11}}, {16{8'h22}}, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, "R6");
    // R7: scalar form; upper lanes saturate but must not count.
    op({{15{8'h7F}}, 8'h01}, {{15{8'hFF}}, 8'h02}, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, "R7");
    op({{7{16'h7FFF}}, 16'h8000}, {{7{16'hFFFF}}, 16'h0001}, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, "R7");
    clear_qc("R7");
    op({{3{32'hFFFF_FFFF}}, 32'h5}, {{3{32'h7FFF_FFFF}}, 32'h6}, 2'd2, 1'b1, 1'b1, 1'b0, 1'b0, "R7");
    op({64'hFFFF_FFFF_FFFF_FFFF, 64'h1}, {64'h7FFF_FFFF_FFFF_FFFF, 64'h2}, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0, "R7");
    idle(1);
    // R8: half-width vector; saturating upper lanes must not count.
    op({{8{8'h7F}}, {8{8'h01}}}, {{8{8'hFF}}, {8{8'h01}}}, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, "R8");
    op({{2{32'hFFFF_FFFF}}, 64'h0000_0001_0000_0001}, {{2{32'h7FFF_FFFF}}, 64'h1}, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0, "R8");
    // R9: hold of outputs across idle cycles.
    idle(4);

    for (int i = 0; i < 3000; i++) begin
      logic [1:0] sz;
      bit m, sc, fu, cl;
      sz = 2'($urandom_range(0, 3));
      m  = 1'($urandom_range(0, 1));
      sc = ($urandom_range(0, 3) == 0);
      fu = ($urandom_range(0, 3) != 0);
      cl = ($urandom_range(0, 15) == 0);
      op(pick_word(), pick_word(), sz, m, sc, fu, cl, m ? "R2" : "R1");
      if ($urandom_range(0, 7) == 0) idle(1);
    end
    idle(3);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule